// File: doc/BRIEF.md
# Synchronous Serial Port

This block is a shift-register serial port that moves one word at a time over a clock line, a data-in line and a data-out line. A single engine serves both roles. As clock owner it builds the serial clock from the system clock through a 4-bit divide select. As clocked device it follows a serial clock from outside, passing it through a two-flop synchronizer and acting on its edges in the system clock domain. Words are 8 or 16 bits long and travel either least- or most-significant bit first.

Software-side control is a small register port. A 7-bit mode register and a 16-bit data register are both writable only while the port is idle. The data register is loaded with the word to send and holds the word received once the transfer ends. A start strobe launches a transfer. A busy flag and a one-cycle completion pulse report progress. The serial clock rests high. Data out changes with the falling serial clock edge, and data in is captured on the rising edge.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, sck_out is 1, sck_oe is 1, busy and done_irq are 0, sout is 0, data_q is 0 and the mode register is 0 (clock-owner role, LSB first, 8-bit word, divide select 0).
- R2: Mode bits [6:3] hold the divide select S. In the clock-owner role with H = S+1, sck_out goes low on the clock edge that accepts start. It then runs one period per bit, low for exactly H system clocks and high for exactly H system clocks, and stays high when idle.
- R3: The first bit appears on sout on the edge that accepts start. Each later bit appears on the edge where sck falls. sout is otherwise unchanged, including while idle.
- R4: Mode bit 1 selects the bit order: 0 sends and receives the least significant bit first, 1 sends and receives the most significant bit first. sin is captured on each rising sck edge.
- R5: Mode bit 2 selects the word length: 0 moves 8 bits through data_q[7:0] and leaves data_q[15:8] unchanged, 1 moves all 16 bits. At completion data_q holds the received word.
- R6: Mode bit 0 = 1 selects the clocked-device role. sck_in passes through two synchronizing flops, and its edges then drive the shifting. The transfer ends on the rising edge of the last bit. The external clock must stay low and stay high for at least 4 system clocks each.
- R7: busy is 1 from the cycle after start is accepted until completion. done_irq is 1 for exactly one cycle, the first cycle in which busy is 0 again. In the clock-owner role this cycle comes 2·H·N cycles after start is accepted, where N is the word length.
- R8: While busy is 1, start, data writes and mode writes are ignored.
- R9: sck_oe is 1 in the clock-owner role and 0 in the clocked-device role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 7 | Mode value: [0] device role, [1] MSB first, [2] 16-bit, [6:3] divide select |
| data_we | input | 1 | Write strobe for the data register |
| data_wdata | input | 16 | Word to transmit |
| start | input | 1 | Starts a transfer when idle |
| sck_in | input | 1 | External serial clock for the clocked-device role |
| sin | input | 1 | Serial data in |
| sck_out | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Drive enable for sck_out |
| sout | output | 1 | Serial data out |
| data_q | output | 16 | Data register: transmit word, then received word |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
The bench keeps a cycle model of the clock-owner waveform and compares it to sck_out, sout, busy and done_irq on every cycle. Each transfer uses different divide selects, and the shortest divide of one clock per phase is included, so an off-by-one in the phase counter shows up as a stretched or shortened phase. Loopback runs and runs against a second instance in the clocked-device role cover every order and length combination. A reversed shift direction or a wrong capture edge would corrupt the received word, and an 8-bit transfer that touched the upper byte would alter data_q[15:8]. Start, data and mode writes are also issued mid-transfer. A design that honoured them would restart the waveform, change the result or change the next transfer's timing.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int DIV_W  = 4;
  localparam int MODE_W = DIV_W + 3;

  typedef struct packed {
    logic [DIV_W-1:0] div_sel;
    logic             long_word;
    logic             msb_first;
    logic             device_role;
  } mode_t;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic             final_i,
  input  logic [DIV_W-1:0] half_sel_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             end_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic             tick;

  assign tick = run_i && (cnt_q == half_sel_i);

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (restart_i) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (run_i) begin
      if (tick) begin
        cnt_d = '0;
        if (!sck_q)       sck_d = 1'b1;
        else if (!final_i) sck_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
      sck_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck_o  = sck_q;
  assign rise_o = tick && !sck_q;
  assign fall_o = tick && sck_q && !final_i;
  assign end_o  = tick && sck_q && final_i;

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !restart_i) |=> sck_q);
  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= half_sel_i));
endmodule

// File: rtl/ssp_sck_sync.sv
module ssp_sck_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] pipe_q, pipe_d;

  always_comb pipe_d = {pipe_q[1:0], sck_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= 3'b111;
    else        pipe_q <= pipe_d;
  end

  assign rise_o = pipe_q[1] && !pipe_q[2];
  assign fall_o = !pipe_q[1] && pipe_q[2];
endmodule

// File: rtl/ssp_shift_core.sv
module ssp_shift_core #(
  parameter int LONG_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [LONG_W-1:0] load_val_i,
  input  logic              start_i,
  input  logic              msb_i,
  input  logic              long_i,
  input  logic              device_i,
  input  logic              sin_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              end_i,
  output logic [LONG_W-1:0] data_o,
  output logic              sout_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              all_in_o
);
  localparam int CNT_W = $clog2(LONG_W + 1);

  logic [LONG_W-1:0] sh_q, sh_d, shifted;
  logic [CNT_W-1:0]  bitcnt_q, bitcnt_d, nbits;
  logic              busy_q, busy_d, done_q, done_d, sout_q, sout_d;
  logic              head_bit, last_bit;

  assign nbits    = long_i ? CNT_W'(LONG_W) : CNT_W'(SHORT_W);
  assign last_bit = (bitcnt_q == nbits - 1'b1);
  assign head_bit = msb_i ? (long_i ? sh_q[LONG_W-1] : sh_q[SHORT_W-1]) : sh_q[0];

  always_comb begin
    if (long_i)
      shifted = msb_i ? {sh_q[LONG_W-2:0], sin_i} : {sin_i, sh_q[LONG_W-1:1]};
    else
      shifted = msb_i ? {sh_q[LONG_W-1:SHORT_W], sh_q[SHORT_W-2:0], sin_i}
                      : {sh_q[LONG_W-1:SHORT_W], sin_i, sh_q[SHORT_W-1:1]};
  end

  always_comb begin
    sh_d     = sh_q;
    bitcnt_d = bitcnt_q;
    busy_d   = busy_q;
    sout_d   = sout_q;
    done_d   = 1'b0;
    if (!busy_q) begin
      if (load_i) sh_d = load_val_i;
      if (start_i) begin
        busy_d   = 1'b1;
        bitcnt_d = '0;
        sout_d   = head_bit;
      end
    end else begin
      if (fall_i) sout_d = head_bit;
      if (rise_i) begin
        sh_d     = shifted;
        bitcnt_d = bitcnt_q + 1'b1;
        if (device_i && last_bit) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
      if (end_i) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      bitcnt_q <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      sout_q   <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      bitcnt_q <= bitcnt_d;
      busy_q   <= busy_d;
      done_q   <= done_d;
      sout_q   <= sout_d;
    end
  end

  assign data_o   = sh_q;
  assign sout_o   = sout_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign all_in_o = busy_q && (bitcnt_q == nbits);

  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));
  assert_idle_sout_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_i) |=> $stable(sout_q));
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (bitcnt_q <= nbits));
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int LONG_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              data_we,
  input  logic [LONG_W-1:0] data_wdata,
  input  logic              start,
  input  logic              sck_in,
  input  logic              sin,
  output logic              sck_out,
  output logic              sck_oe,
  output logic              sout,
  output logic [LONG_W-1:0] data_q,
  output logic              busy,
  output logic              done_irq
);
  mode_t mode_q, mode_d;
  logic  start_go, all_in;
  logic  g_rise, g_fall, g_end, s_rise, s_fall;
  logic  rise_ev, fall_ev;

  always_comb begin
    mode_d = mode_q;
    if (mode_we && !busy) mode_d = mode_t'(mode_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  assign start_go = start && !busy;

  ssp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (start_go && !mode_q.device_role),
    .run_i      (busy && !mode_q.device_role),
    .final_i    (all_in),
    .half_sel_i (mode_q.div_sel),
    .sck_o      (sck_out),
    .rise_o     (g_rise),
    .fall_o     (g_fall),
    .end_o      (g_end)
  );

  ssp_sck_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck_i  (sck_in),
    .rise_o (s_rise),
    .fall_o (s_fall)
  );

  assign rise_ev = mode_q.device_role ? s_rise : g_rise;
  assign fall_ev = mode_q.device_role ? s_fall : g_fall;

  ssp_shift_core #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (data_we),
    .load_val_i (data_wdata),
    .start_i    (start_go),
    .msb_i      (mode_q.msb_first),
    .long_i     (mode_q.long_word),
    .device_i   (mode_q.device_role),
    .sin_i      (sin),
    .rise_i     (rise_ev),
    .fall_i     (fall_ev),
    .end_i      (g_end),
    .data_o     (data_q),
    .sout_o     (sout),
    .busy_o     (busy),
    .done_o     (done_irq),
    .all_in_o   (all_in)
  );

  assign sck_oe = !mode_q.device_role;

  assert_mode_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_we) |=> (mode_q == $past(mode_q)));
  assert_device_sck_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.device_role |-> sck_out);
endmodule

// File: tb/sync_serial_port_test.sv
module sync_serial_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        mode_we, data_we, start, tb_sin;
  logic [6:0]  mode_wdata;
  logic [15:0] data_wdata;
  logic        p_mode_we, p_data_we, p_start;
  logic [6:0]  p_mode_wdata;
  logic [15:0] p_data_wdata;

  logic        u_sck, u_oe, u_sout, u_busy, u_done, u_sin;
  logic [15:0] u_data;
  logic        p_sck, p_oe, p_sout, p_busy, p_done;
  logic [15:0] p_data;

  int          cfg;
  logic [6:0]  cur_mode;
  int          nchk, nerr, p_done_cnt;

  assign u_sin = (cfg == 0) ? tb_sin : (cfg == 1) ? u_sout : p_sout;

  sync_serial_port uut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .start(start),
    .sck_in(1'b1), .sin(u_sin), .sck_out(u_sck), .sck_oe(u_oe),
    .sout(u_sout), .data_q(u_data), .busy(u_busy), .done_irq(u_done));

  sync_serial_port peer (
    .clk(clk), .rst_n(rst_n), .mode_we(p_mode_we), .mode_wdata(p_mode_wdata),
    .data_we(p_data_we), .data_wdata(p_data_wdata), .start(p_start),
    .sck_in(u_sck), .sin(u_sout), .sck_out(p_sck), .sck_oe(p_oe),
    .sout(p_sout), .data_q(p_data), .busy(p_busy), .done_irq(p_done));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  always @(negedge clk) if (p_done) p_done_cnt++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic bitof(input logic [15:0] w, input int k, input int n, input bit msb);
    return msb ? w[n-1-k] : w[k];
  endfunction

  task automatic set_mode(input logic [6:0] m);
    @(negedge clk); mode_we = 1'b1; mode_wdata = m;
    @(negedge clk); mode_we = 1'b0;
    cur_mode = m;
  endtask

  task automatic set_data(input logic [15:0] d);
    @(negedge clk); data_we = 1'b1; data_wdata = d;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic peer_setup(input logic [6:0] m, input logic [15:0] d);
    @(negedge clk); p_mode_we = 1'b1; p_mode_wdata = m; p_data_we = 1'b0;
    @(negedge clk); p_mode_we = 1'b0; p_data_we = 1'b1; p_data_wdata = d;
    @(negedge clk); p_data_we = 1'b0; p_start = 1'b1;
    @(negedge clk); p_start = 1'b0;
  endtask

  // Reference model of one clock-owner transfer, compared every cycle.
  task automatic xfer(input logic [15:0] tx, input logic [15:0] rxw, input bit poke);
    int h, n;
    bit msb;
    logic [15:0] exp_word;
    h   = int'(cur_mode[6:3]) + 1;
    n   = cur_mode[2] ? 16 : 8;
    msb = cur_mode[1];
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 2 * h * n; c++) begin
      int  k;
      bit  lowph;
      k     = c / (2 * h);
      lowph = (c % (2 * h)) < h;
      if (cfg == 0) tb_sin = bitof(rxw, k, n, msb);
      chk(u_sck == !lowph, "R2 sck phase", u_sck, !lowph);
      chk(u_sout == bitof(tx, k, n, msb), "R3 R4 sout bit", u_sout, bitof(tx, k, n, msb));
      chk(u_busy && !u_done, "R7 busy during transfer", {u_busy, u_done}, 2'b10);
      if (poke && c == 3) begin
        data_we = 1'b1; data_wdata = ~tx;
        mode_we = 1'b1; mode_wdata = ~cur_mode;
        start   = 1'b1;
      end else if (poke && c == 4) begin
        data_we = 1'b0; mode_we = 1'b0; start = 1'b0;
      end
      @(negedge clk);
    end
    chk(!u_busy && u_done, "R7 completion pulse", {u_busy, u_done}, 2'b01);
    chk(u_sck == 1'b1, "R2 sck idles high", u_sck, 1'b1);
    @(negedge clk);
    chk(!u_done, "R7 pulse lasts one cycle", u_done, 1'b0);
    exp_word = (n == 16) ? rxw : {tx[15:8], rxw[7:0]};
    chk(u_data == exp_word, "R4 R5 received word", u_data, exp_word);
  endtask

  task automatic pair_run(input logic [6:0] m, input logic [15:0] utx, input logic [15:0] ptx);
    logic [15:0] pexp;
    cfg = 2;
    p_done_cnt = 0;
    peer_setup(m | 7'h01, ptx);
    set_mode(m);
    set_data(utx);
    xfer(utx, ptx, 1'b0);
    pexp = m[2] ? utx : {ptx[15:8], utx[7:0]};
    chk(!p_busy, "R6 device finished", p_busy, 1'b0);
    chk(p_data == pexp, "R6 device received word", p_data, pexp);
    chk(p_done_cnt == 1, "R6 R7 device done count", p_done_cnt, 1);
    chk(p_oe == 1'b0 && u_oe == 1'b1, "R9 clock drive enable", {p_oe, u_oe}, 2'b01);
  endtask

  initial begin
    nchk = 0; nerr = 0;
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R7 watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg = 0; tb_sin = 1'b0; p_done_cnt = 0;
    mode_we = 0; data_we = 0; start = 0; mode_wdata = '0; data_wdata = '0;
    p_mode_we = 0; p_data_we = 0; p_start = 0; p_mode_wdata = '0; p_data_wdata = '0;
    cur_mode = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(u_sck && u_oe, "R1 sck and enable", {u_sck, u_oe}, 2'b11);
    chk(!u_busy && !u_done, "R1 busy and done", {u_busy, u_done}, 2'b00);
    chk(u_data == 16'h0 && !u_sout, "R1 data and sout", {u_data, u_sout}, 17'h0);

    // R2 R4 R5: external data source, various divides and orders
    cfg = 0;
    set_data(16'h3CA5);
    xfer(16'h3CA5, 16'h1234, 1'b0);               // reset mode: H=1, LSB, 8-bit
    set_mode(7'b0010_0_1_0); set_data(16'h81C3);  // H=3, MSB, 8-bit
    xfer(16'h81C3, 16'hBE6D, 1'b0);
    set_mode(7'b0001_1_0_0); set_data(16'hA00F);  // H=2, LSB, 16-bit
    xfer(16'hA00F, 16'h5A3C, 1'b0);
    // R8: writes and start during busy are ignored
    set_mode(7'b0101_1_1_0); set_data(16'hC671);  // H=6, MSB, 16-bit
    xfer(16'hC671, 16'h9E02, 1'b1);
    // R8: mode unchanged, same timing expected without rewriting it
    cfg = 1;
    set_data(16'h7B2E);
    xfer(16'h7B2E, 16'h7B2E, 1'b0);
    // R4 R5 loopback, every order/length combination
    for (int m = 0; m < 4; m++) begin
      logic [15:0] w;
      w = 16'h96E1 ^ (16'h1111 * m);
      set_mode({4'(m), m[1] ? 1'b1 : 1'b0, m[0] ? 1'b1 : 1'b0, 1'b0});
      set_data(w);
      xfer(w, w, 1'b0);
    end
    // R6 clock owner to clocked device, every order/length combination
    pair_run(7'b0011_0_0_0, 16'hD2A7, 16'h4C19);
    pair_run(7'b0011_0_1_0, 16'h0FF0, 16'hE38B);
    pair_run(7'b0011_1_0_0, 16'hB5C3, 16'h6A1E);
    pair_run(7'b0111_1_1_0, 16'h2D94, 16'hF07A);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule